// File: doc/BRIEF.md
# Periodic Tick Timer

This block divides a 32768 Hz reference, delivered as a one-cycle enable pulse on `ref_tick`, with a down-counter whose start value software programs through a byte-wide register port. To get an event rate of 2^k Hz, software loads the reload registers with 0x8000 shifted right by k, so 1 Hz takes 0x8000. Each time the count runs out, a sticky expiry flag is raised. The interrupt line follows that flag whenever interrupts are enabled. In periodic mode the counter reloads itself and keeps running. In one-shot mode it stops.

The usual start sequence is as follows. Software waits until the busy bit of the control register reads 0, sets the run bit, and then writes any value to the restart register so that the count begins afresh. The busy bit stays high for a short, fixed number of cycles after each control write. The expiry flag is cleared by writing 1 to its own bit position.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: Control register at address 0x10 has these bits: bit 0 = periodic mode (1 periodic, 0 one-shot), bit 1 = expiry flag, bit 2 = interrupt enable, bit 3 = run. Bits 0, 2 and 3 are written directly and read back. Bits 6:4 always read 0.
- R3: The reload value is split into two registers. The low byte is at 0x12 and the high byte is at 0x13. Both read back what was written.
- R4: A control write with bit 3 set while the timer is stopped loads the counter from the reload value. The counter then drops by one on each `ref_tick` pulse, and it expires on the pulse that brings it to zero, which is the reload-th pulse. A reload value of 0 expires after 65536 pulses. While the timer is stopped, `ref_tick` has no effect.
- R5: Expiry sets the flag (bit 1), and the flag stays set. In periodic mode the counter reloads at expiry and expires again after another reload-value pulses.
- R6: In one-shot mode, expiry clears the run bit (bit 3).
- R7: A control write with bit 1 = 1 clears the flag, and one with bit 1 = 0 leaves it unchanged. If an expiry happens in the same cycle as a clearing write, the flag ends up set.
- R8: `irq` is 1 exactly when the flag and the interrupt enable (bit 2) are both 1.
- R9: Bit 7 of the control register reads 1 during the two cycles that follow any control write, and 0 at all other times. Writing to bit 7 has no effect.
- R10: Any write to address 0x20 reloads the counter from the current reload value, so the pulse count starts over. Address 0x20 reads 0.
- R11: A new reload value written while the timer runs takes effect only at the next load or reload.
- R12: Writes to addresses other than 0x10, 0x12, 0x13 and 0x20 change nothing, and such addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse at the 32768 Hz reference rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rdata | output | 8 | Read data for `rd_addr` (combinational) |
| irq | output | 1 | Interrupt: expiry flag AND interrupt enable |

## Verification
The bench builds the block with its defaults: a 16-bit counter and a busy window of two cycles. With these values the full-range case is affordable: a reload of 0 runs 65536 back-to-back pulses before it expires. Small reloads of 3 to 6 reach every expiry, reload, restart and same-cycle clear corner within a few cycles each. The two-cycle busy window is short enough for each of its cycle boundaries to be checked directly.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   localparam logic [7:0] ADDR_CTRL    = 8'h10;
   localparam logic [7:0] ADDR_RLD_LO  = 8'h12;
   localparam logic [7:0] ADDR_RLD_HI  = 8'h13;
   localparam logic [7:0] ADDR_RESTART = 8'h20;

   localparam int BIT_MODE = 0;
   localparam int BIT_FLAG = 1;
   localparam int BIT_IE   = 2;
   localparam int BIT_RUN  = 3;
   localparam int BIT_BUSY = 7;

   typedef struct packed {
      logic run;
      logic ie;
      logic flag;
      logic periodic;
   } ctrl_t;
endpackage

// File: rtl/tt_busy.sv
module tt_busy #(
   parameter int BUSY_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (BUSY_CYCLES == 0) begin : g_none
         logic unused_in;
         assign unused_in = start ^ clk ^ rst_n;
         assign busy = 1'b0;
      end else begin : g_cnt
         localparam int BW = $clog2(BUSY_CYCLES + 1);
         logic [BW-1:0] left;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              left <= '0;
            else if (start)          left <= BW'(BUSY_CYCLES);
            else if (left != '0)     left <= left - BW'(1);
         end
         assign busy = (left != '0);
      end
   endgenerate
endmodule

// File: rtl/tt_regs.sv
module tt_regs
   import tick_timer_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [7:0]       rd_addr,
   input  logic             expire,
   input  logic             busy,
   output ctrl_t            ctrl,
   output logic [CNT_W-1:0] reload,
   output logic             ctrl_wr,
   output logic             restart_wr,
   output logic             run_start,
   output logic [7:0]       rdata
);
   localparam int HI_W = CNT_W - 8;

   logic [7:0]      rld_lo;
   logic [HI_W-1:0] rld_hi;
   logic            lo_wr, hi_wr;

   assign ctrl_wr    = wr_en && (wr_addr == ADDR_CTRL);
   assign lo_wr      = wr_en && (wr_addr == ADDR_RLD_LO);
   assign hi_wr      = wr_en && (wr_addr == ADDR_RLD_HI);
   assign restart_wr = wr_en && (wr_addr == ADDR_RESTART);
   assign run_start  = ctrl_wr && wr_data[BIT_RUN] && !ctrl.run;
   assign reload     = {rld_hi, rld_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         rld_lo <= '0;
         rld_hi <= '0;
      end else begin
         if (ctrl_wr) begin
            ctrl.periodic <= wr_data[BIT_MODE];
            ctrl.ie       <= wr_data[BIT_IE];
            ctrl.run      <= wr_data[BIT_RUN];
         end else if (expire && !ctrl.periodic) begin
            ctrl.run <= 1'b0;
         end
         // a fresh expiry outranks a clearing write
         ctrl.flag <= expire | (ctrl.flag & ~(ctrl_wr & wr_data[BIT_FLAG]));
         if (lo_wr) rld_lo <= wr_data;
         if (hi_wr) rld_hi <= wr_data[HI_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (rd_addr)
         ADDR_CTRL: begin
            rdata[BIT_MODE] = ctrl.periodic;
            rdata[BIT_FLAG] = ctrl.flag;
            rdata[BIT_IE]   = ctrl.ie;
            rdata[BIT_RUN]  = ctrl.run;
            rdata[BIT_BUSY] = busy;
         end
         ADDR_RLD_LO: rdata = rld_lo;
         ADDR_RLD_HI: rdata[HI_W-1:0] = rld_hi;
         default:     rdata = '0;
      endcase
   end
endmodule

// File: rtl/tt_down_counter.sv
module tt_down_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] reload,
   output logic             expire,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // a stored 0 wraps through all ones, so reload 0 spans 2**CNT_W pulses
   assign expire = run && ref_tick && !load && (count == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count <= '0;
      else if (load)             count <= reload;
      else if (run && ref_tick)  count <= (count == ONE) ? reload : count - ONE;
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int BUSY_CYCLES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_tick,
   input  logic       wr_en,
   input  logic [7:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [7:0] rd_addr,
   output logic [7:0] rdata,
   output logic       irq
);
   generate
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
         $error("tick_timer: CNT_W must lie in 9..16");
      end
      if (BUSY_CYCLES < 0 || BUSY_CYCLES > 15) begin : g_bad_busy
         $error("tick_timer: BUSY_CYCLES must lie in 0..15");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] count;
   logic             ctrl_wr, restart_wr, run_start, load, expire, busy;

   assign load = run_start | restart_wr;

   tt_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .expire(expire), .busy(busy),
      .ctrl(ctrl), .reload(reload), .ctrl_wr(ctrl_wr),
      .restart_wr(restart_wr), .run_start(run_start), .rdata(rdata)
   );

   tt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run(ctrl.run),
      .load(load), .reload(reload), .expire(expire), .count(count)
   );

   tt_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(ctrl_wr), .busy(busy)
   );

   assign irq = ctrl.flag & ctrl.ie;
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
   parameter int CNT_W       = 16,
   parameter int BUSY_CYCLES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_wr,
   input logic             clr_bit,
   input logic             expire,
   input logic             flag,
   input logic             run,
   input logic             periodic,
   input logic             load,
   input logic             busy,
   input logic [CNT_W-1:0] count
);
   assert_flag_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag);

   assert_flag_rise_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(expire));

   assert_oneshot_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !periodic && !ctrl_wr) |=> !run);

   assert_flag_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(ctrl_wr && clr_bit));

   assert_count_holds_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(count));

   generate
      if (BUSY_CYCLES > 0) begin : g_busy_chk
         assert_busy_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_wr |=> busy);
      end
   endgenerate
endmodule

bind tick_timer tt_checker #(.CNT_W(CNT_W), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .clr_bit(wr_data[1]),
   .expire(expire), .flag(ctrl.flag), .run(ctrl.run),
   .periodic(ctrl.periodic), .load(load), .busy(busy), .count(count)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rdata;
   logic       irq;

   always #2 clk = ~clk;

   tick_timer i_tick_timer (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rdata(rdata), .irq(irq)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_req = "R1";

   // behavioural reference state
   int m_mode = 0, m_flag = 0, m_ie = 0, m_run = 0, m_busy = 0;
   int m_lo = 0, m_hi = 0, m_cnt = 0;

   task automatic report(string req, string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int m_read(int a);
      case (a)
         8'h10: return (m_busy > 0 ? 128 : 0) + m_run * 8 + m_ie * 4 + m_flag * 2 + m_mode;
         8'h12: return m_lo;
         8'h13: return m_hi;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_flag = 0; m_ie = 0; m_run = 0; m_busy = 0;
         m_lo = 0; m_hi = 0; m_cnt = 0;
      end else begin
         int  rl, d;
         bit  cw, rw, ld, ex;
         rl = m_hi * 256 + m_lo;
         d  = int'(wr_data);
         cw = wr_en && wr_addr == 8'h10;
         rw = wr_en && wr_addr == 8'h20;
         ld = (cw && d[3] && m_run == 0) || rw;
         ex = m_run == 1 && ref_tick && !ld && m_cnt == 1;
         if (ld) m_cnt = rl;
         else if (m_run == 1 && ref_tick) m_cnt = (m_cnt == 1) ? rl : ((m_cnt + 65535) % 65536);
         m_flag = (ex || (m_flag == 1 && !(cw && d[1]))) ? 1 : 0;
         if (cw) begin
            m_mode = d[0]; m_ie = d[2]; m_run = d[3];
         end else if (ex && m_mode == 0) m_run = 0;
         m_busy = cw ? 2 : (m_busy > 0 ? m_busy - 1 : 0);
         if (wr_en && wr_addr == 8'h12) m_lo = d;
         if (wr_en && wr_addr == 8'h13) m_hi = d;
      end
      #1;
      report(cur_req, "rdata vs model", int'(rdata), m_read(int'(rd_addr)));
      report(cur_req, "irq vs model (R8)", int'(irq), m_flag & m_ie);
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pulses(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ref_tick = 1'b1;
         @(negedge clk); ref_tick = 1'b0;
         repeat (gap) @(negedge clk);
      end
   endtask

   task automatic burst(input int n);
      @(negedge clk); ref_tick = 1'b1;
      repeat (n - 1) @(negedge clk);
      @(negedge clk); ref_tick = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [7:0] a, input int exp);
      @(negedge clk); rd_addr = a;
      #1 report(req, "register read", int'(rdata), exp);
   endtask

   task automatic flag_check(input string req, input int exp);
      @(negedge clk); rd_addr = 8'h10;
      #1 report(req, "expiry flag", int'(rdata[1]), exp);
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cur_req = "R1";
      rd_check("R1", 8'h10, 0);
      rd_check("R1", 8'h12, 0);
      rd_check("R1", 8'h13, 0);
      report("R1", "irq after reset", int'(irq), 0);

      // R2 / R9 control fields and busy window
      cur_req = "R2";
      wr(8'h10, 8'h05);
      rd_check("R9", 8'h10, 8'h85);
      rd_check("R9", 8'h10, 8'h05);
      wr(8'h10, 8'hF0);
      rd_check("R2", 8'h10, 8'h80);
      rd_check("R2", 8'h10, 8'h00);

      // R3 reload bytes
      cur_req = "R3";
      wr(8'h12, 8'h34);
      wr(8'h13, 8'hAB);
      rd_check("R3", 8'h12, 8'h34);
      rd_check("R3", 8'h13, 8'hAB);

      // R12 stray addresses
      cur_req = "R12";
      wr(8'h11, 8'hFF);
      wr(8'h30, 8'hFF);
      rd_check("R12", 8'h11, 0);
      rd_check("R12", 8'h12, 8'h34);
      rd_check("R12", 8'h10, 0);

      // R4 / R6 / R8 one-shot of 5 pulses with interrupt enabled
      cur_req = "R4";
      wr(8'h12, 8'h05);
      wr(8'h13, 8'h00);
      wr(8'h10, 8'h0C);
      pulses(4, 1);
      flag_check("R4", 0);
      report("R8", "irq before expiry", int'(irq), 0);
      pulses(1, 1);
      flag_check("R4", 1);
      report("R8", "irq at expiry", int'(irq), 1);
      rd_check("R6", 8'h10, 8'h06);
      cur_req = "R5";
      pulses(3, 0);
      flag_check("R5", 1);

      // R7 clear semantics
      cur_req = "R7";
      wr(8'h10, 8'h04);
      flag_check("R7", 1);
      wr(8'h10, 8'h06);
      flag_check("R7", 0);
      report("R8", "irq after clear", int'(irq), 0);

      // R5 periodic with interrupt disabled
      cur_req = "R5";
      wr(8'h12, 8'h03);
      wr(8'h10, 8'h09);
      pulses(3, 0);
      flag_check("R5", 1);
      report("R8", "irq with enable off", int'(irq), 0);
      wr(8'h10, 8'h0B);
      flag_check("R7", 0);
      pulses(2, 2);
      flag_check("R5", 0);
      pulses(1, 2);
      flag_check("R5", 1);

      // R11 reload change while running
      cur_req = "R11";
      wr(8'h12, 8'h06);
      wr(8'h10, 8'h0B);
      pulses(3, 0);
      flag_check("R11", 1);
      wr(8'h10, 8'h0B);
      pulses(5, 0);
      flag_check("R11", 0);
      pulses(1, 0);
      flag_check("R11", 1);

      // R10 restart register
      cur_req = "R10";
      wr(8'h10, 8'h0B);
      pulses(4, 0);
      wr(8'h20, 8'h5A);
      pulses(5, 0);
      flag_check("R10", 0);
      pulses(1, 0);
      flag_check("R10", 1);
      rd_check("R10", 8'h20, 0);

      // R7 expiry and clearing write in the same cycle
      cur_req = "R7";
      wr(8'h10, 8'h0B);
      pulses(5, 0);
      @(negedge clk); wr_en = 1'b1; wr_addr = 8'h10; wr_data = 8'h0B; ref_tick = 1'b1;
      @(negedge clk); wr_en = 1'b0; ref_tick = 1'b0;
      flag_check("R7", 1);

      // R4 ticks ignored while stopped
      cur_req = "R4";
      wr(8'h10, 8'h02);
      pulses(10, 0);
      flag_check("R4", 0);

      // R4 reload of zero spans 65536 pulses
      wr(8'h12, 8'h00);
      wr(8'h13, 8'h00);
      wr(8'h10, 8'h08);
      burst(65535);
      flag_check("R4", 0);
      pulses(1, 0);
      flag_check("R4", 1);
      rd_check("R6", 8'h10, 8'h02);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule